// File: doc/BRIEF.md
# Byte Program Sequencer for Command-Driven Flash

This block runs on the host side of a flash device and writes one byte at a time. Each attempt, called a pulse, has four steps. The sequencer writes a program-setup command, then writes the data byte to the target address. It waits for a fixed number of clock cycles, writes a verify command, and then reads the target location back.

If the byte read back differs from the intended value, the whole four-step attempt is repeated. This continues until the byte matches or until a fixed pulse limit is reached. At the end the block raises a one-cycle completion strobe, a fail flag and the number of pulses it spent.

A client streams bytes by issuing one request after another. The client sends a separate end-of-job request when it is finished, so that the device goes back to normal read mode. Every device access goes out through a valid/ready master port. A transfer completes in the cycle where both valid and ready are high, and read data is sampled in that cycle.

Top module: `byte_prog_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `bus_valid`, `done`, `fail` and `pulses` are all 0.
- R2: Each pulse is four master-port transfers in this order:
  - a write of 40h;
  - a write of the request byte to the request address;
  - a write of C0h;
  - a read (`bus_we` = 0) of the request address.
  The three writes also carry the request address.
- R3: After the data write completes, `bus_valid` stays low for exactly `WAIT_CYC` cycles before the verify command is presented.
- R4: When the first read-back equals the request byte, `done` pulses with `fail` = 0 and `pulses` = 1. No further transfer follows.
- R5: A read-back that differs from the request byte starts a new pulse with a fresh 40h write. `pulses` reports how many pulses were used, so a byte that matches on its third read finishes with `pulses` = 3 after 12 transfers.
- R6: After `MAX_TRIES` pulses without a match, `done` pulses with `fail` = 1 and `pulses` = `MAX_TRIES`, and no further transfer is issued.
- R7: A request is taken only in a cycle where `req_ready` is 1. `req_ready` is 0 while a job runs, and a request presented during a job starts nothing.
- R8: A request with `req_eoj` = 1 issues exactly one transfer, a write of 00h to address 0. It then pulses `done` with `fail` = 0 and `pulses` = 0.
- R9: While `bus_valid` is 1 and `bus_ready` is 0, the sequencer holds `bus_valid`, `bus_we`, `bus_addr` and `bus_wdata` unchanged.
- R10: `done` is high for a single cycle. `fail` and `pulses` keep their values until the next request is taken.
- R11: A request presented in the cycle `done` is high is taken at once, and its pulses use the new address and byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_eoj | input | 1 | 1 = return device to read mode, 0 = program a byte |
| req_addr | input | AW | Target byte address |
| req_data | input | DW | Byte to program |
| req_ready | output | 1 | Sequencer idle, request taken this cycle if valid |
| bus_valid | output | 1 | Master transfer presented |
| bus_ready | input | 1 | Device accepts the transfer |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Transfer address |
| bus_wdata | output | DW | Write data or command code |
| bus_rdata | input | DW | Read data, valid when a read completes |
| done | output | 1 | One-cycle job completion strobe |
| fail | output | 1 | Last byte job hit the pulse limit |
| pulses | output | CW | Pulses used by the last job |

## Verification
The main function is exercised against three behaviours of the device model:
- a byte that matches on its first read-back, which fixes the four-transfer order and the wait gap;
- a byte that matches only on its third read-back, which shows that a mismatch restarts the full pulse rather than just the verify step, and that the pulse count accumulates;
- a byte that never matches, which separates the limit exit from the success exit and shows that no 26th pulse starts.

The same programming job is also run with `bus_ready` toggling, to show that stalls change neither the transfer order nor the result. A request is presented mid-job to show it is dropped, and another is presented in the same cycle as `done` to show it is taken at once.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PROG,
    ST_WAIT,
    ST_VCMD,
    ST_VREAD,
    ST_RDMODE
  } bpc_state_e;

  localparam logic [7:0] CMD_PGM_SETUP = 8'h40;
  localparam logic [7:0] CMD_PGM_CHECK = 8'hC0;
  localparam logic [7:0] CMD_READ_MODE = 8'h00;
endpackage

// File: rtl/bpc_wait_timer.sv
module bpc_wait_timer #(
  parameter int WAIT_CYC = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int TW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [TW-1:0] LOAD_VAL = TW'(WAIT_CYC - 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? LOAD_VAL : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/bpc_try_counter.sv
module bpc_try_counter #(
  parameter int MAX_TRIES = 25,
  parameter int CW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          at_max
);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_TRIES);

  logic [CW-1:0] cnt_q;
  logic          cnt_en;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_en = clr || (inc && (cnt_q != LIMIT));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count  = cnt_q;
  assign at_max = (cnt_q == LIMIT);
endmodule

// File: rtl/bpc_seq.sv
module bpc_seq
  import bpc_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_eoj,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          req_ready,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          tmr_expired,
  output logic          tmr_load,
  input  logic          try_at_max,
  output logic          try_clr,
  output logic          try_inc,
  output logic          done,
  output logic          fail
);
  bpc_state_e    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          done_q, fail_q;
  logic          hs, take, fin, fin_fail;

  assign hs   = bus_valid && bus_ready;
  assign take = req_valid && (state_q == ST_IDLE);

  // next-state
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    try_clr  = take;
    try_inc  = 1'b0;
    fin      = 1'b0;
    fin_fail = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (take) state_d = req_eoj ? ST_RDMODE : ST_SETUP;
      ST_SETUP:  if (hs) state_d = ST_PROG;
      ST_PROG: begin
        if (hs) begin
          try_inc  = 1'b1;
          tmr_load = 1'b1;
          state_d  = ST_WAIT;
        end
      end
      ST_WAIT:   if (tmr_expired) state_d = ST_VCMD;
      ST_VCMD:   if (hs) state_d = ST_VREAD;
      ST_VREAD: begin
        if (hs) begin
          if (bus_rdata == data_q) begin
            fin     = 1'b1;
            state_d = ST_IDLE;
          end else if (try_at_max) begin
            fin      = 1'b1;
            fin_fail = 1'b1;
            state_d  = ST_IDLE;
          end else begin
            state_d = ST_SETUP;
          end
        end
      end
      ST_RDMODE: begin
        if (hs) begin
          fin     = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default:   state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (take) begin
        addr_q <= req_addr;
        data_q <= req_data;
      end
      if (take) fail_q <= 1'b0;
      else if (fin) fail_q <= fin_fail;
    end
  end

  // master port drive, decoded from state
  always_comb begin
    bus_valid = 1'b1;
    bus_we    = 1'b1;
    bus_addr  = addr_q;
    bus_wdata = DW'(CMD_PGM_SETUP);
    unique case (state_q)
      ST_SETUP:  bus_wdata = DW'(CMD_PGM_SETUP);
      ST_PROG:   bus_wdata = data_q;
      ST_VCMD:   bus_wdata = DW'(CMD_PGM_CHECK);
      ST_VREAD:  bus_we    = 1'b0;
      ST_RDMODE: begin
        bus_wdata = DW'(CMD_READ_MODE);
        bus_addr  = '0;
      end
      default:   bus_valid = 1'b0;
    endcase
  end

  assign req_ready = (state_q == ST_IDLE);
  assign done      = done_q;
  assign fail      = fail_q;
endmodule

// File: rtl/byte_prog_ctrl.sv
module byte_prog_ctrl #(
  parameter int AW        = 15,
  parameter int DW        = 8,
  parameter int MAX_TRIES = 25,
  parameter int WAIT_CYC  = 2500,
  localparam int CW       = $clog2(MAX_TRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_eoj,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          req_ready,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          done,
  output logic          fail,
  output logic [CW-1:0] pulses
);
  logic rst_meta, rst_sync;
  logic tmr_load, tmr_expired;
  logic try_clr, try_inc, try_at_max;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  bpc_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync),
    .req_valid   (req_valid),
    .req_eoj     (req_eoj),
    .req_addr    (req_addr),
    .req_data    (req_data),
    .req_ready   (req_ready),
    .bus_valid   (bus_valid),
    .bus_ready   (bus_ready),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .try_at_max  (try_at_max),
    .try_clr     (try_clr),
    .try_inc     (try_inc),
    .done        (done),
    .fail        (fail)
  );

  bpc_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_sync),
    .load    (tmr_load),
    .expired (tmr_expired)
  );

  bpc_try_counter #(.MAX_TRIES(MAX_TRIES), .CW(CW)) u_try (
    .clk    (clk),
    .rst_n  (rst_sync),
    .clr    (try_clr),
    .inc    (try_inc),
    .count  (pulses),
    .at_max (try_at_max)
  );
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker #(
  parameter int AW        = 15,
  parameter int DW        = 8,
  parameter int MAX_TRIES = 25,
  parameter int CW        = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          done,
  input logic          fail,
  input logic [CW-1:0] pulses
);
  // R9: a stalled transfer keeps its fields
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

  // R7: never ready for a request while a transfer is out
  assert_busy_no_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !req_ready);

  // R10: completion strobe lasts one cycle
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: count holds unless a request is taken or a transfer completes
  assert_pulses_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) && !(bus_valid && bus_ready) |=> $stable(pulses));

  // R6: pulse count never passes the limit
  assert_pulse_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pulses <= CW'(MAX_TRIES));

  // R6: a failure is only reported at the limit
  assert_fail_at_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && fail |-> pulses == CW'(MAX_TRIES));
endmodule

bind byte_prog_ctrl bpc_checker #(
  .AW(AW), .DW(DW), .MAX_TRIES(MAX_TRIES), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .done      (done),
  .fail      (fail),
  .pulses    (pulses)
);

// File: tb/byte_prog_ctrl_tb.sv
module byte_prog_ctrl_tb;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int MAXT = 25;
  localparam int WAITC = 12;
  localparam int CW = $clog2(MAXT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_eoj = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, bus_valid, bus_we, done, fail;
  logic bus_ready = 1'b1;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic [CW-1:0] pulses;

  always #2 clk = ~clk;

  byte_prog_ctrl #(.AW(AW), .DW(DW), .MAX_TRIES(MAXT), .WAIT_CYC(WAITC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_eoj(req_eoj),
    .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .fail(fail), .pulses(pulses)
  );

  int n_chk = 0;
  int n_fail = 0;

  // device model state
  logic [7:0] mem [256];
  int mode = 0;
  int seen = 0;
  int need = 1;
  int stall = 0;
  bit tog = 1'b0;
  bit log_we [256];
  int log_addr [256];
  int log_data [256];
  int log_n = 0;
  bit gap_on = 1'b0;
  int gap = 0;
  int last_gap = -1;

  always @(negedge clk) begin
    bus_ready = (stall != 0) ? tog : 1'b1;
    tog = ~tog;
    if (gap_on) begin
      if (bus_valid) begin
        last_gap = gap;
        gap_on = 1'b0;
      end else gap++;
    end
    if (rst_n && bus_valid && bus_ready) begin
      if (log_n < 256) begin
        log_we[log_n] = bus_we;
        log_addr[log_n] = int'(bus_addr);
        log_data[log_n] = int'(bus_wdata);
        log_n++;
      end
      if (bus_we) begin
        if (mode == 1) begin
          seen++;
          if (seen >= need) mem[bus_addr] = bus_wdata;
          mode = 3;
          gap_on = 1'b1;
          gap = 0;
        end else if (bus_wdata == 8'h40) mode = 1;
        else if (bus_wdata == 8'hC0) mode = 2;
        else mode = 0;
      end else begin
        bus_rdata = mem[bus_addr];
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic prep(input int nd);
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    log_n = 0;
    seen = 0;
    need = nd;
    last_gap = -1;
  endtask

  task automatic issue(input bit eoj, input int a, input int d);
    req_valid = 1'b1;
    req_eoj = eoj;
    req_addr = AW'(a);
    req_data = DW'(d);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done, req, int'(done), 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(bus_valid == 1'b0, "R1 bus_valid", int'(bus_valid), 0);
    chk(done == 1'b0 && fail == 1'b0, "R1 done/fail", int'({done, fail}), 0);
    chk(pulses == '0, "R1 pulses", int'(pulses), 0);
  endtask

  task automatic t_single();
    prep(1);
    @(negedge clk);
    issue(1'b0, 8'h3A, 8'h5C);
    wait_done("R4 done");
    chk(fail == 1'b0, "R4 fail", int'(fail), 0);
    chk(pulses == 1, "R4 pulses", int'(pulses), 1);
    chk(log_n == 4, "R2 transfer count", log_n, 4);
    chk(log_we[0] && log_data[0] == 8'h40 && log_addr[0] == 8'h3A, "R2 setup", log_data[0], 8'h40);
    chk(log_we[1] && log_data[1] == 8'h5C && log_addr[1] == 8'h3A, "R2 data write", log_data[1], 8'h5C);
    chk(log_we[2] && log_data[2] == 8'hC0, "R2 verify cmd", log_data[2], 8'hC0);
    chk(!log_we[3] && log_addr[3] == 8'h3A, "R2 read", log_addr[3], 8'h3A);
    chk(last_gap == WAITC, "R3 wait gap", last_gap, WAITC);
    repeat (10) @(negedge clk);
    chk(log_n == 4, "R4 no more transfers", log_n, 4);
  endtask

  task automatic t_retry();
    prep(3);
    issue(1'b0, 8'h11, 8'h22);
    wait_done("R5 done");
    chk(fail == 1'b0, "R5 fail", int'(fail), 0);
    chk(pulses == 3, "R5 pulses", int'(pulses), 3);
    chk(log_n == 12, "R5 transfers", log_n, 12);
    chk(log_data[4] == 8'h40 && log_data[8] == 8'h40, "R5 full restart", log_data[8], 8'h40);
    chk(last_gap == WAITC, "R3 gap on retry", last_gap, WAITC);
  endtask

  task automatic t_limit();
    prep(1000);
    issue(1'b0, 8'h07, 8'h00);
    wait_done("R6 done");
    chk(fail == 1'b1, "R6 fail", int'(fail), 1);
    chk(pulses == MAXT, "R6 pulses", int'(pulses), MAXT);
    repeat (30) @(negedge clk);
    chk(log_n == 4 * MAXT, "R6 no extra pulse", log_n, 4 * MAXT);
  endtask

  task automatic t_busy();
    prep(2);
    issue(1'b0, 8'h40, 8'h99);
    repeat (3) @(negedge clk);
    req_valid = 1'b1;
    req_eoj = 1'b0;
    req_addr = 8'hEE;
    req_data = 8'h01;
    repeat (4) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R7 busy ready", int'(req_ready), 0);
    end
    req_valid = 1'b0;
    wait_done("R7 done");
    repeat (10) @(negedge clk);
    chk(log_n == 8, "R7 ignored request", log_n, 8);
    chk(log_addr[7] == 8'h40, "R7 address kept", log_addr[7], 8'h40);
  endtask

  task automatic t_eoj();
    prep(1);
    issue(1'b1, 8'h55, 8'h66);
    wait_done("R8 done");
    chk(fail == 1'b0 && pulses == 0, "R8 fail/pulses", int'(pulses), 0);
    chk(log_n == 1, "R8 one transfer", log_n, 1);
    chk(log_we[0] && log_data[0] == 0 && log_addr[0] == 0, "R8 read-mode write", log_data[0], 0);
  endtask

  task automatic t_stall();
    prep(2);
    stall = 1;
    issue(1'b0, 8'h81, 8'h3C);
    wait_done("R9 done");
    stall = 0;
    chk(fail == 1'b0 && pulses == 2, "R9 result under stall", int'(pulses), 2);
    chk(log_n == 8 && log_data[5] == 8'h3C && !log_we[7], "R9 order under stall", log_n, 8);
  endtask

  task automatic t_hold();
    prep(2);
    issue(1'b0, 8'h10, 8'h20);
    wait_done("R10 done");
    @(negedge clk);
    chk(done == 1'b0, "R10 single strobe", int'(done), 0);
    repeat (5) @(negedge clk);
    chk(pulses == 2 && fail == 1'b0, "R10 result held", int'(pulses), 2);
  endtask

  task automatic t_b2b();
    prep(1);
    issue(1'b0, 8'h01, 8'hA5);
    wait_done("R11 first done");
    prep(1);
    req_valid = 1'b1;
    req_eoj = 1'b0;
    req_addr = 8'h02;
    req_data = 8'h5A;
    chk(req_ready == 1'b1, "R11 ready with done", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done("R11 second done");
    chk(log_addr[1] == 8'h02 && log_data[1] == 8'h5A, "R11 new target", log_addr[1], 8'h02);
    chk(pulses == 1 && fail == 1'b0, "R11 result", int'(pulses), 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_retry();
    t_limit();
    t_busy();
    t_eoj();
    t_stall();
    t_hold();
    t_b2b();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule